// File: doc/BRIEF.md
# Channel Output Combiner with Latched Fault Flag

This block decides, cycle by cycle, whether each of a set of power output channels (six by default) is switched on. Every channel has a parallel control pin and a stored control bit written over the serial interface. One global merge setting, also written over the serial interface, chooses whether the pin and the stored bit are combined by OR or by AND. The parallel pins pass through a two-flop synchronizer before they are combined. A common active-high allow input forces every channel off when it is low. The reset input clears all state.

The block also keeps a sticky per-channel fault register fed by event pulses from external detection circuits. It drives an active-low fault flag that a host can use as an interrupt. A clear strobe empties the register. An event that arrives in the same cycle as the clear still ends up latched, so no event is lost.

Top module: `chan_gate_top`

## Requirements
- R1: With the merge setting at OR (`sel_and` written as 0), channel i is on when its synchronized pin `par_in[i]` or its stored bit is 1.
- R2: With the merge setting at AND (`sel_and` written as 1), channel i is on only when both its synchronized pin and its stored bit are 1.
- R3: A `cmd_wr` pulse loads the stored bits from `cmd_word[11:6]`, with bit 6 going to channel 0 and bit 11 to channel 5. All other bits of `cmd_word` have no effect on any output.
- R4: A `sel_wr` pulse loads the merge setting from `sel_and`, where 1 means AND and 0 means OR. After reset the setting is OR and every stored bit is 0.
- R5: While `allow_i` is low at a clock edge, every bit of `chan_on_o` is 0 after that edge, whatever the other inputs are.
- R6: A change on `par_in` reaches `chan_on_o` after the third rising edge. A change of the stored bits or of the merge setting reaches it after the second rising edge.
- R7: While `rst_n` is low, `chan_on_o` is all 0 and `fault_n_o` is 1. All stored bits, the merge setting, the synchronizer and the fault register return to their reset values.
- R8: Any 1 on `flt_evt` at a clock edge latches that channel's fault, and `fault_n_o` is 0 after that edge.
- R9: Latched faults stay set until a `flt_clr` pulse. After a clear with no event in the same cycle, `fault_n_o` returns to 1.
- R10: An event on the same edge as `flt_clr` wins over the clear and stays latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | 6 | Parallel channel control pins, active high |
| cmd_wr | input | 1 | Load strobe for the channel command word |
| cmd_word | input | 16 | Serial channel command word, bits 11:6 are channel bits |
| sel_wr | input | 1 | Load strobe for the merge setting |
| sel_and | input | 1 | Merge setting: 1 AND, 0 OR |
| allow_i | input | 1 | Global allow, low forces all channels off |
| flt_evt | input | 6 | Per-channel fault event pulses |
| flt_clr | input | 1 | Clear strobe for the fault register |
| chan_on_o | output | 6 | Channel on/off states |
| fault_n_o | output | 1 | Active-low general fault flag |

## Verification
The bench targets the latency difference between the synchronized pins and the stored bits. A design that synchronized both paths, or neither, would show a channel change one cycle early or late. It writes command words with bits set only outside the channel field, which a misaligned field decode would turn into live channels. It raises a fault event on the same edge as the clear, which a clear-first design would drop with the flag high. It also resets in the middle of a run after AND mode and stored bits have been set, so a design that kept the merge setting through reset would leave channels off when their pins are high.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;

    typedef enum logic {
        MERGE_OR  = 1'b0,
        MERGE_AND = 1'b1
    } merge_mode_e;

endpackage

// File: rtl/chan_gate_sync.sv
module chan_gate_sync #(
    parameter int NCH    = 6,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] async_i,
    output logic [NCH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [NCH-1:0] stage_d [STAGES];
    logic [NCH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/chan_gate_merge.sv
module chan_gate_merge
    import chan_gate_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int CMD_W  = 16,
    parameter int CH_LSB = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pin_sync_i,
    input  logic             cmd_wr_i,
    input  logic [CMD_W-1:0] cmd_word_i,
    input  logic             sel_wr_i,
    input  logic             sel_and_i,
    input  logic             allow_i,
    output logic [NCH-1:0]   chan_on_o
);
    localparam int CH_MSB = CH_LSB + NCH - 1;

    typedef struct packed {
        logic [NCH-1:0] bits;
        merge_mode_e    mode;
        logic [NCH-1:0] out;
    } merge_st_t;

    merge_st_t st_d, st_q;
    logic [NCH-1:0] merged;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_comb begin
            if (st_q.mode == MERGE_AND) begin
                merged[g] = pin_sync_i[g] & st_q.bits[g];
            end else begin
                merged[g] = pin_sync_i[g] | st_q.bits[g];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmd_wr_i) begin
            st_d.bits = cmd_word_i[CH_MSB:CH_LSB];
        end
        if (sel_wr_i) begin
            st_d.mode = sel_and_i ? MERGE_AND : MERGE_OR;
        end
        st_d.out = allow_i ? merged : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: '0, mode: MERGE_OR, out: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_on_o = st_q.out;

endmodule

// File: rtl/chan_gate_fault.sv
module chan_gate_fault #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic           clr_i,
    output logic           fault_n_o
);
    typedef struct packed {
        logic [NCH-1:0] latched;
    } fault_st_t;

    fault_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.latched = '0;
        end
        st_d.latched = st_d.latched | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{latched: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_n_o = ~(|st_q.latched);

endmodule

// File: rtl/chan_gate_top.sv
module chan_gate_top #(
    parameter int NCH         = 6,
    parameter int CMD_W       = 16,
    parameter int CH_LSB      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   par_in,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             sel_wr,
    input  logic             sel_and,
    input  logic             allow_i,
    input  logic [NCH-1:0]   flt_evt,
    input  logic             flt_clr,
    output logic [NCH-1:0]   chan_on_o,
    output logic             fault_n_o
);
    localparam bit FIELD_FITS = (CH_LSB + NCH) <= CMD_W;

    initial begin
        if (!FIELD_FITS) begin
            $display("chan_gate_top: channel field exceeds command width");
        end
    end

    logic [NCH-1:0] pin_sync;

    chan_gate_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (par_in),
        .sync_o  (pin_sync)
    );

    chan_gate_merge #(.NCH(NCH), .CMD_W(CMD_W), .CH_LSB(CH_LSB)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync_i (pin_sync),
        .cmd_wr_i   (cmd_wr),
        .cmd_word_i (cmd_word),
        .sel_wr_i   (sel_wr),
        .sel_and_i  (sel_and),
        .allow_i    (allow_i),
        .chan_on_o  (chan_on_o)
    );

    chan_gate_fault #(.NCH(NCH)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (flt_evt),
        .clr_i     (flt_clr),
        .fault_n_o (fault_n_o)
    );

endmodule

// File: rtl/chan_gate_chk.sv
module chan_gate_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           allow_i,
    input logic [NCH-1:0] flt_evt,
    input logic           flt_clr,
    input logic [NCH-1:0] chan_on_o,
    input logic           fault_n_o
);
    // R5
    allow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !allow_i |=> (chan_on_o == '0));

    // R8
    evt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_evt) |=> !fault_n_o);

    // R9
    sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && !flt_clr) |=> !fault_n_o);

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr && (flt_evt == '0)) |=> fault_n_o);

    // R10
    clr_evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr && (|flt_evt)) |=> !fault_n_o);

endmodule

bind chan_gate_top chan_gate_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .allow_i   (allow_i),
    .flt_evt   (flt_evt),
    .flt_clr   (flt_clr),
    .chan_on_o (chan_on_o),
    .fault_n_o (fault_n_o)
);

// File: tb/sim_chan_gate_top.sv
`timescale 1ns/1ps
module sim_chan_gate_top;
    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] par_in = '0;
    logic           cmd_wr = 1'b0;
    logic [15:0]    cmd_word = '0;
    logic           sel_wr = 1'b0;
    logic           sel_and = 1'b0;
    logic           allow_i = 1'b1;
    logic [NCH-1:0] flt_evt = '0;
    logic           flt_clr = 1'b0;
    logic [NCH-1:0] chan_on_o;
    logic           fault_n_o;

    always #2 clk = ~clk;

    chan_gate_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_in    (par_in),
        .cmd_wr    (cmd_wr),
        .cmd_word  (cmd_word),
        .sel_wr    (sel_wr),
        .sel_and   (sel_and),
        .allow_i   (allow_i),
        .flt_evt   (flt_evt),
        .flt_clr   (flt_clr),
        .chan_on_o (chan_on_o),
        .fault_n_o (fault_n_o)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R7";

    // reference model state
    int             m_bits;
    bit             m_and;
    int             m_diag;
    int             m_out;
    int             pipe[$];

    task automatic model_reset();
        m_bits = 0; m_and = 0; m_diag = 0; m_out = 0;
        pipe = {};
        pipe.push_back(0);
        pipe.push_back(0);
    endtask

    task automatic compare();
        bit exp_fn;
        exp_fn = (m_diag == 0);
        checks++;
        if (int'(chan_on_o) != m_out) begin
            errors++;
            $display("FAIL %s chan_on_o actual %b expected %b", tag, chan_on_o, m_out[NCH-1:0]);
        end
        checks++;
        if (fault_n_o != exp_fn) begin
            errors++;
            $display("FAIL %s fault_n_o actual %b expected %b", tag, fault_n_o, exp_fn);
        end
    endtask

    // one clock: model evaluates with inputs as they stand before the edge
    task automatic tick();
        int s = pipe[0];
        int merged = m_and ? (s & m_bits) : (s | m_bits);
        m_out = allow_i ? (merged & 'h3f) : 0;
        void'(pipe.pop_front());
        pipe.push_back(int'(par_in));
        if (cmd_wr) m_bits = (int'(cmd_word) >> 6) & 'h3f;
        if (sel_wr) m_and = sel_and;
        if (flt_clr) m_diag = 0;
        m_diag = m_diag | int'(flt_evt);
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 0; sel_wr = 0; flt_evt = '0; flt_clr = 0;
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        #1;
        compare();
        @(negedge clk);
        @(negedge clk);
        compare();
        rst_n = 1;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        tag = "R7";
        do_reset();
        ticks(3);

        // R4 default OR with bits 0, R1 pin path latency R6
        tag = "R6";
        par_in = 6'b000101; ticks(1);
        par_in = 6'b000000; ticks(5);
        tag = "R1";
        par_in = 6'b100001; ticks(4);
        cmd_word = 16'h0001 << 6 | 16'h0020 << 6; cmd_wr = 1; ticks(1);
        par_in = 6'b010010; ticks(4);

        // R3 only bits 11:6 count
        tag = "R3";
        cmd_word = 16'hF03F; cmd_wr = 1; par_in = '0; ticks(4);
        cmd_word = 16'h0FC0; cmd_wr = 1; ticks(3);
        cmd_word = 16'h0040; cmd_wr = 1; ticks(3);

        // R2 AND mode, R4 select
        tag = "R2";
        sel_and = 1; sel_wr = 1; ticks(1);
        sel_and = 0; ticks(3);
        cmd_word = 16'h0A80; cmd_wr = 1; par_in = 6'b111000; ticks(5);
        par_in = 6'b000111; ticks(4);
        tag = "R4";
        sel_and = 0; sel_wr = 1; ticks(3);

        // R5 allow
        tag = "R5";
        par_in = 6'b111111; ticks(4);
        allow_i = 0; ticks(3);
        allow_i = 1; ticks(2);
        allow_i = 0; ticks(1);
        allow_i = 1; ticks(2);

        // R8 R9 R10 faults
        tag = "R8";
        flt_evt = 6'b000100; ticks(3);
        tag = "R9";
        flt_clr = 1; ticks(2);
        flt_evt = 6'b100000; ticks(1);
        flt_evt = 6'b000001; ticks(4);
        flt_clr = 1; ticks(2);
        tag = "R10";
        flt_evt = 6'b010000; ticks(1);
        flt_clr = 1; flt_evt = 6'b001000; ticks(3);
        flt_clr = 1; ticks(2);

        // R7 mid-run reset after AND mode, stored bits, latched fault
        tag = "R7";
        sel_and = 1; sel_wr = 1; ticks(1);
        cmd_word = 16'h0000; cmd_wr = 1; flt_evt = 6'b000010; ticks(2);
        do_reset();
        par_in = 6'b011000; ticks(5);

        // mixed stimulus
        tag = "R1 R2 R5 R8";
        for (int i = 0; i < 400; i++) begin
            int r = $urandom;
            par_in   = r[5:0];
            cmd_wr   = r[6];
            cmd_word = 16'($urandom);
            sel_wr   = (r[9:7] == 0);
            sel_and  = r[10];
            allow_i  = (r[13:11] != 0);
            flt_evt  = (r[16:14] == 0) ? 6'(1 << r[19:17] % 6) : '0;
            flt_clr  = (r[22:20] == 0);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule